// File: doc/BRIEF.md
# Serial Bus Read-Only Slave Transmitter

This block is the target side of a two-wire serial bus (I2C) for read transfers only. It watches the clock and data lines through synchronizers and glitch filters. It detects START and STOP conditions and collects the first byte after a START. When the upper seven bits of that byte equal the programmed own address, it acknowledges. When the low bit of the byte requests a read, it switches itself into transmit mode. Both pad drivers are open-drain and are modelled as pull-low enables.

Bytes to send come from a local controller through a one-byte holding register. At every point where a new byte must start, the block copies the holding register into its shift register. If the holding register is empty at that point, the block holds the clock line low until the controller writes a byte. Each byte sets an event flag, which can raise an interrupt. The block also records the acknowledge bit the master returns. A NACK from the master sends the block back to idle. Writing 0xFF as the final byte keeps the data line released so the master can end the transfer.

Top module: `i2c_rd_slave`

## Requirements
- R1: After a START, the first byte is the address byte. Its upper 7 bits, sent MSB first, are compared with own_addr_i. On a match, the block pulls SDA low for the whole ninth clock and sets irq_flag_o. On a mismatch, SDA stays released.
- R2: Bit 0 of a matching address byte is the direction bit. When it is 1, tx_mode_o becomes 1 with no controller action. When it is 0, tx_mode_o stays 0 and the block drives nothing after the acknowledge.
- R3: A new byte must start after the address acknowledge and after every data byte the master acknowledges. If tx_empty_o is 1 at that point, the block holds SCL low (scl_oe_o=1) until the controller writes data.
- R4: A write (wr_i) loads the holding register and clears tx_empty_o. The byte moves to the shift register only when a byte must start. On that move, tx_empty_o, irq_flag_o and xfer_flag_o are all set to 1. A byte written while another is being shifted waits in the holding register, and no stretch follows.
- R5: irq_flag_o is set by the rising SCL edge of the ninth clock of every data byte.
- R6: ack_n_o captures SDA at the ninth clock of each data byte: 0 means the byte was acknowledged, 1 means it was not. The reset value is 1.
- R7: irq_o is 1 only when irq_flag_o and irq_en_i are both 1. flag_clr_i clears irq_flag_o and xfer_flag_o.
- R8: A data byte of 0xFF leaves SDA undriven for all of its eight bits.
- R9: busy_o is set by a START (SDA falls while SCL is high) and cleared by a STOP (SDA rises while SCL is high).
- R10: Data bits leave MSB first. sda_oe_o changes only while SCL is low.
- R11: Each input passes a 2-flop synchronizer and a filter that needs 3 equal samples. A pulse of 1 or 2 clock cycles has no effect.
- R12: After a NACK from the master, both pad enables drop and stay low until the next START.
- R13: While en_i is 0, the block drives neither line and does not respond to its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable |
| irq_en_i | input | 1 | Interrupt enable |
| own_addr_i | input | 7 | Own 7-bit bus address |
| scl_i | input | 1 | Sensed SCL line |
| sda_i | input | 1 | Sensed SDA line |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low |
| wr_i | input | 1 | Holding register write strobe |
| wr_data_i | input | 8 | Data to transmit |
| flag_clr_i | input | 1 | Clear event and transfer flags |
| irq_o | output | 1 | Interrupt request |
| irq_flag_o | output | 1 | Event flag |
| xfer_flag_o | output | 1 | Byte moved to shift register |
| tx_empty_o | output | 1 | Holding register empty |
| ack_n_o | output | 1 | Last master acknowledge (0 = ACK) |
| busy_o | output | 1 | Bus busy |
| tx_mode_o | output | 1 | Transmit mode active |

## Verification
The hardest case to reach is the hand-off between two data bytes: the master acknowledges while the next byte is already waiting in the holding register. The bench reaches it with a directed multi-byte read. The controller writes the second byte while the first byte is still on the wire. The bench then checks that no clock stretch follows and that the second byte comes out unchanged. A bus monitor records any SDA change while SCL is high, and any pull on SDA during a 0xFF byte. The glitch filter is checked with one-cycle and two-cycle SDA pulses on an idle bus.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ADDR = 3'd1,
    S_AACK = 3'd2,
    S_LOAD = 3'd3,
    S_TX   = 3'd4,
    S_TACK = 3'd5
  } eng_state_t;
endpackage

// File: rtl/i2cs_filter.sv
module i2cs_filter #(
  parameter int N_LINES  = 2,
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] raw_i,
  output logic [N_LINES-1:0] filt_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [SYNC_LEN-1:0] sync_q;
    logic [FILT_LEN-1:0] hist_q;
    logic                out_q, out_nx;

    always_comb begin
      out_nx = out_q;
      if (&hist_q)       out_nx = 1'b1;
      else if (~|hist_q) out_nx = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '1;
        hist_q <= '1;
        out_q  <= 1'b1;
      end else begin
        sync_q <= {sync_q[SYNC_LEN-2:0], raw_i[g]};
        hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
        out_q  <= out_nx;
      end
    end

    assign filt_o[g] = out_q;
  end
endmodule

// File: rtl/i2cs_linemon.sv
module i2cs_linemon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_p_q, sda_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_f_i;
      sda_p_q <= sda_f_i;
    end
  end

  assign scl_rise_o = scl_f_i & ~scl_p_q;
  assign scl_fall_o = ~scl_f_i & scl_p_q;
  assign start_o    = scl_f_i & scl_p_q & sda_p_q & ~sda_f_i;
  assign stop_o     = scl_f_i & scl_p_q & ~sda_p_q & sda_f_i;
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_i,
  input  logic              irq_en_i,
  input  logic              load_i,
  input  logic              aflag_i,
  input  logic              dflag_i,
  input  logic              dack_i,
  output logic [DATA_W-1:0] hold_o,
  output logic              hold_valid_o,
  output logic              tx_empty_o,
  output logic              irq_flag_o,
  output logic              xfer_flag_o,
  output logic              ack_n_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] hold_q, hold_nx;
  logic empty_q, empty_nx, flag_q, flag_nx, xfer_q, xfer_nx, ackn_q, ackn_nx;

  always_comb begin
    hold_nx  = hold_q;
    empty_nx = empty_q;
    flag_nx  = flag_q;
    xfer_nx  = xfer_q;
    ackn_nx  = ackn_q;
    if (load_i) empty_nx = 1'b1;
    if (wr_i) begin
      hold_nx  = wr_data_i;
      empty_nx = 1'b0;
    end
    if (clr_i) begin
      flag_nx = 1'b0;
      xfer_nx = 1'b0;
    end
    if (load_i | aflag_i | dflag_i) flag_nx = 1'b1;
    if (load_i) xfer_nx = 1'b1;
    if (dflag_i) ackn_nx = dack_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
      flag_q  <= 1'b0;
      xfer_q  <= 1'b0;
      ackn_q  <= 1'b1;
    end else begin
      hold_q  <= hold_nx;
      empty_q <= empty_nx;
      flag_q  <= flag_nx;
      xfer_q  <= xfer_nx;
      ackn_q  <= ackn_nx;
    end
  end

  assign hold_o       = hold_q;
  assign hold_valid_o = ~empty_q;
  assign tx_empty_o   = empty_q;
  assign irq_flag_o   = flag_q;
  assign xfer_flag_o  = xfer_q;
  assign ack_n_o      = ackn_q;
  assign irq_o        = flag_q & irq_en_i;

  AST_LOAD_REFILLS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !wr_i) |=> (tx_empty_o && irq_flag_o && xfer_flag_o)); // R4
  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !load_i && !aflag_i && !dflag_i) |=> !irq_flag_o); // R7
  AST_ACK_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    dflag_i |=> (ack_n_o == $past(dack_i))); // R6
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_f_i,
  input  logic              sda_f_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              hold_valid_i,
  input  logic [DATA_W-1:0] hold_i,
  output logic              load_o,
  output logic              aflag_o,
  output logic              dflag_o,
  output logic              dack_o,
  output logic              sda_drv_o,
  output logic              scl_hold_o,
  output logic              tx_mode_o,
  output logic              busy_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  eng_state_t        state_q, state_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic [DATA_W-1:0] sh_q, sh_nx;
  logic drv_q, drv_nx, txm_q, txm_nx, busy_q, busy_nx, ack_q, ack_nx;

  always_comb begin
    state_nx = state_q;
    cnt_nx   = cnt_q;
    sh_nx    = sh_q;
    drv_nx   = drv_q;
    txm_nx   = txm_q;
    busy_nx  = busy_q;
    ack_nx   = ack_q;
    load_o   = 1'b0;
    aflag_o  = 1'b0;
    dflag_o  = 1'b0;
    if (!en_i) begin
      state_nx = S_IDLE;
      drv_nx   = 1'b0;
      txm_nx   = 1'b0;
      busy_nx  = 1'b0;
    end else if (start_i) begin
      state_nx = S_ADDR;
      cnt_nx   = '0;
      drv_nx   = 1'b0;
      txm_nx   = 1'b0;
      busy_nx  = 1'b1;
    end else if (stop_i) begin
      state_nx = S_IDLE;
      drv_nx   = 1'b0;
      txm_nx   = 1'b0;
      busy_nx  = 1'b0;
    end else begin
      case (state_q)
        S_ADDR: begin
          if (scl_rise_i) begin
            sh_nx  = {sh_q[DATA_W-2:0], sda_f_i};
            cnt_nx = cnt_q + 1'b1;
          end
          if (scl_fall_i && cnt_q == LAST_BIT) begin
            if (sh_q[DATA_W-1:1] == own_addr_i) begin
              state_nx = S_AACK;
              drv_nx   = 1'b1;
              txm_nx   = sh_q[0];
              aflag_o  = 1'b1;
            end else begin
              state_nx = S_IDLE;
            end
          end
        end
        S_AACK: begin
          if (scl_fall_i) begin
            drv_nx   = 1'b0;
            state_nx = txm_q ? S_LOAD : S_IDLE;
          end
        end
        S_LOAD: begin
          if (hold_valid_i) begin
            sh_nx    = hold_i;
            drv_nx   = ~hold_i[DATA_W-1];
            cnt_nx   = '0;
            load_o   = 1'b1;
            state_nx = S_TX;
          end
        end
        S_TX: begin
          if (scl_rise_i) cnt_nx = cnt_q + 1'b1;
          if (scl_fall_i) begin
            if (cnt_q == LAST_BIT) begin
              drv_nx   = 1'b0;
              state_nx = S_TACK;
            end else begin
              sh_nx  = {sh_q[DATA_W-2:0], 1'b0};
              drv_nx = ~sh_q[DATA_W-2];
            end
          end
        end
        S_TACK: begin
          if (scl_rise_i) begin
            ack_nx  = sda_f_i;
            dflag_o = 1'b1;
          end
          if (scl_fall_i) begin
            if (!ack_q) begin
              state_nx = S_LOAD;
            end else begin
              state_nx = S_IDLE;
              txm_nx   = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      drv_q   <= 1'b0;
      txm_q   <= 1'b0;
      busy_q  <= 1'b0;
      ack_q   <= 1'b1;
    end else begin
      state_q <= state_nx;
      cnt_q   <= cnt_nx;
      sh_q    <= sh_nx;
      drv_q   <= drv_nx;
      txm_q   <= txm_nx;
      busy_q  <= busy_nx;
      ack_q   <= ack_nx;
    end
  end

  assign dack_o     = sda_f_i;
  assign sda_drv_o  = drv_q;
  assign scl_hold_o = (state_q == S_LOAD) && !hold_valid_i && en_i;
  assign tx_mode_o  = txm_q;
  assign busy_o     = busy_q;

  AST_ADDR_ACK_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_AACK && $past(state_q) == S_ADDR) |-> drv_q); // R1
  AST_STRETCH_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold_o |-> !scl_f_i); // R3
  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_TX && scl_f_i && $past(scl_f_i)) |-> $stable(drv_q)); // R10
  AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !busy_q); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> (!drv_q && !scl_hold_o)); // R12
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && $past(!en_i)) |-> (!drv_q && !scl_hold_o)); // R13
endmodule

// File: rtl/i2c_rd_slave.sv
module i2c_rd_slave #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              irq_en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              flag_clr_i,
  output logic              irq_o,
  output logic              irq_flag_o,
  output logic              xfer_flag_o,
  output logic              tx_empty_o,
  output logic              ack_n_o,
  output logic              busy_o,
  output logic              tx_mode_o
);
  localparam int LINES = 2;

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [LINES-1:0] filt;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic load, aflag, dflag, dack, hold_valid;
  logic [DATA_W-1:0] hold;

  i2cs_filter #(.N_LINES(LINES), .SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n_s), .raw_i({sda_i, scl_i}), .filt_o(filt)
  );

  i2cs_linemon u_mon (
    .clk(clk), .rst_n(rst_n_s), .scl_f_i(filt[0]), .sda_f_i(filt[1]),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
  );

  i2cs_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n_s), .en_i(en_i), .own_addr_i(own_addr_i),
    .scl_f_i(filt[0]), .sda_f_i(filt[1]), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .hold_valid_i(hold_valid), .hold_i(hold),
    .load_o(load), .aflag_o(aflag), .dflag_o(dflag), .dack_o(dack),
    .sda_drv_o(sda_oe_o), .scl_hold_o(scl_oe_o), .tx_mode_o(tx_mode_o), .busy_o(busy_o)
  );

  i2cs_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_i(wr_i), .wr_data_i(wr_data_i), .clr_i(flag_clr_i),
    .irq_en_i(irq_en_i), .load_i(load), .aflag_i(aflag), .dflag_i(dflag), .dack_i(dack),
    .hold_o(hold), .hold_valid_o(hold_valid), .tx_empty_o(tx_empty_o),
    .irq_flag_o(irq_flag_o), .xfer_flag_o(xfer_flag_o), .ack_n_o(ack_n_o), .irq_o(irq_o)
  );
endmodule

// File: tb/i2c_rd_slave_tb_top.sv
module i2c_rd_slave_tb_top;
  localparam int P = 16;
  localparam logic [6:0] OWN = 7'h2A;
  localparam int NVEC = 5;
  // {addr[16:10], rw[9], ie[8], data[7:0]}
  localparam logic [16:0] VEC [NVEC] = '{
    {7'h2A, 1'b1, 1'b1, 8'hA5},
    {7'h2A, 1'b1, 1'b0, 8'h3C},
    {7'h15, 1'b1, 1'b1, 8'h00},
    {7'h2A, 1'b0, 1'b1, 8'h00},
    {7'h2A, 1'b1, 1'b1, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, ie = 1'b1, wr = 1'b0, clr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, irq, irq_flag, xfer_flag, tx_empty, ack_n, busy, tx_mode;
  wire  scl_line = scl_m & ~scl_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   n_chk = 0, n_fail = 0, cyc = 0;
  logic mon_on = 1'b0, sda_pulled = 1'b0, hi_change = 1'b0, scl_p = 1'b1, sda_p = 1'b1;

  always #2 clk = ~clk;

  i2c_rd_slave dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .irq_en_i(ie), .own_addr_i(OWN),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .wr_i(wr), .wr_data_i(wdata), .flag_clr_i(clr), .irq_o(irq), .irq_flag_o(irq_flag),
    .xfer_flag_o(xfer_flag), .tx_empty_o(tx_empty), .ack_n_o(ack_n), .busy_o(busy),
    .tx_mode_o(tx_mode)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mon_on) begin
      if (sda_oe) sda_pulled <= 1'b1;
      if (scl_line && scl_p && sda_line != sda_p) hi_change <= 1'b1;
    end
    scl_p <= scl_line;
    sda_p <= sda_line;
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic cpu_write(input logic [7:0] d);
    @(negedge clk) begin wr = 1'b1; wdata = d; end
    @(negedge clk) wr = 1'b0;
  endtask

  task automatic bus_start();
    @(negedge clk) begin sda_m = 1'b1; scl_m = 1'b1; end
    wait_cyc(P);
    sda_m = 1'b0;
    wait_cyc(P);
    scl_m = 1'b0;
    wait_cyc(P);
  endtask

  task automatic bus_stop();
    @(negedge clk) sda_m = 1'b0;
    wait_cyc(P);
    scl_m = 1'b1;
    wait_cyc(P);
    sda_m = 1'b1;
    wait_cyc(P);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    @(negedge clk) sda_m = b;
    wait_cyc(P);
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
    wait_cyc(P / 2);
    r = sda_line;
    wait_cyc(P / 2);
    scl_m = 1'b0;
    wait_cyc(P);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_bit);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, ack_bit);
  endtask

  task automatic read_byte(output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      d[i] = r;
    end
  endtask

  initial begin : main
    logic ackb, r;
    logic [7:0] d;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(6);
    // reset state
    check("R9 reset busy", busy, 0);
    check("R3 reset scl_oe", scl_oe, 0);
    check("R12 reset sda_oe", sda_oe, 0);
    check("R4 reset tx_empty", tx_empty, 1);
    check("R7 reset flag", irq_flag, 0);
    check("R6 reset ack_n", ack_n, 1);
    check("R2 reset tx_mode", tx_mode, 0);

    // table walk: single-byte transfers
    for (int v = 0; v < NVEC; v++) begin
      logic [6:0] a;
      logic rw, ven;
      logic [7:0] dv;
      logic match;
      a = VEC[v][16:10]; rw = VEC[v][9]; ven = VEC[v][8]; dv = VEC[v][7:0];
      match = (a == OWN);
      ie = ven;
      pulse_clr();
      bus_start();
      check("R9 start sets busy", busy, 1);
      send_byte({a, rw}, ackb);
      check("R1 address ack", ackb, !match);
      check("R1 address flag", irq_flag, match);
      check("R2 direction", tx_mode, match && rw);
      if (match && rw) begin
        check("R3 stretch while empty", scl_oe, 1);
        pulse_clr();
        cpu_write(dv);
        wait_cyc(2);
        check("R3 stretch released", scl_oe, 0);
        check("R4 empty set again", tx_empty, 1);
        check("R4 flag set on load", irq_flag, 1);
        check("R4 xfer flag set", xfer_flag, 1);
        check("R7 irq gated", irq, ven);
        pulse_clr();
        check("R7 clear flag", irq_flag, 0);
        sda_pulled = 1'b0; hi_change = 1'b0; mon_on = 1'b1;
        read_byte(d);
        mon_on = 1'b0;
        check("R10 data MSB first", d, dv);
        check("R10 sda stable while SCL high", hi_change, 0);
        if (dv == 8'hFF) check("R8 0xFF leaves SDA released", sda_pulled, 0);
        clk_bit(1'b1, r);  // master NACK
        check("R5 flag on ninth data clock", irq_flag, 1);
        check("R6 nack captured", ack_n, 1);
        wait_cyc(4);
        check("R12 sda released after nack", sda_oe, 0);
        check("R12 scl released after nack", scl_oe, 0);
        check("R12 tx_mode dropped", tx_mode, 0);
      end else begin
        wait_cyc(4);
        check("R2 no drive after write or miss", sda_oe | scl_oe, 0);
      end
      bus_stop();
      check("R9 stop clears busy", busy, 0);
    end

    // directed: two bytes, second preloaded during first
    ie = 1'b1;
    pulse_clr();
    bus_start();
    send_byte({OWN, 1'b1}, ackb);
    check("R1 ack for multi", ackb, 0);
    cpu_write(8'h81);
    wait_cyc(2);
    cpu_write(8'h7E);
    check("R4 preload holds", tx_empty, 0);
    read_byte(d);
    check("R10 first byte", d, 8'h81);
    pulse_clr();
    clk_bit(1'b0, r);  // master ACK
    check("R6 ack captured", ack_n, 0);
    check("R3 no stretch when preloaded", scl_oe, 0);
    check("R4 preloaded byte moved", tx_empty, 1);
    check("R5 flag after acked byte", irq_flag, 1);
    read_byte(d);
    check("R4 second byte intact", d, 8'h7E);
    clk_bit(1'b0, r);  // ACK again, no data written
    wait_cyc(2);
    check("R3 stretch after ack with empty holding", scl_oe, 1);
    cpu_write(8'hFF);
    sda_pulled = 1'b0; mon_on = 1'b1;
    read_byte(d);
    mon_on = 1'b0;
    check("R8 final 0xFF", d, 8'hFF);
    check("R8 sda untouched", sda_pulled, 0);
    clk_bit(1'b1, r);
    wait_cyc(P);
    check("R12 released after final nack", sda_oe | scl_oe, 0);
    bus_stop();

    // glitch filter on idle bus
    @(negedge clk) sda_m = 1'b0;
    @(negedge clk) sda_m = 1'b1;
    wait_cyc(10);
    check("R11 1-cycle glitch ignored", busy, 0);
    @(negedge clk) sda_m = 1'b0;
    wait_cyc(2);
    sda_m = 1'b1;
    wait_cyc(10);
    check("R11 2-cycle glitch ignored", busy, 0);

    // disabled block
    en = 1'b0;
    bus_start();
    send_byte({OWN, 1'b1}, ackb);
    check("R13 no ack when disabled", ackb, 1);
    check("R13 no busy when disabled", busy, 0);
    check("R13 no stretch when disabled", scl_oe, 0);
    bus_stop();
    en = 1'b1;

    finish_run();
  end
endmodule